// File: doc/BRIEF.md
# Open-Drain Parallel Port Bank

This block holds forty-eight general-purpose lines, split into six byte-wide ports, each line driven only by pulling it low. A host writes a byte to a port address to load that port's output latch; a latch bit of 1 pulls its line low, a bit of 0 releases it to the external pull-up. Reading a port address never returns the latch. It returns the level actually present on the lines after a two-flop synchronizer. The host thereby sees both its own drive and whatever the outside world does to the line. A line serves as an input once its latch bit is 0.

A separate write-protect register holds one bit per port. A set bit freezes that port against host writes, which makes it a read-only input port. The protect register itself can always be written and read back. There is no direction register; direction follows from the latch contents alone.

Top module: `odport_bank`

## Requirements
- R1: While reset is asserted and right after it, every drive output `padPullLow` is 0 (all lines released), the protect register reads 0, and every port reads all ones, the synchronizer reset value of a released line.
- R2: A write with `addr` = k (0 to 5) while protect bit k is 0 loads `wrData` into latch k at that clock edge, and `padPullLow[8k+7:8k]` equals the written byte from then on.
- R3: A write to port k while protect bit k is 1 changes no latch; `padPullLow` keeps its value.
- R4: A write to `addr` = 6 loads `wrData[5:0]` into the protect register at that edge whatever its current value; reading `addr` = 6 returns the register in bits 5:0 and 0 in bits 7:6. Bit k of the register guards port k.
- R5: Reading port k returns, combinationally from `addr`, the line levels `padIn[8k+7:8k]` as they were sampled two rising edges earlier.
- R6: Since a line is the AND of its released state and the external level, a port read shows 0 wherever its own latch bit is 1, and shows the external level wherever the latch bit is 0.
- R7: `addr` = 7 reads as 0, and a write to it changes neither any latch nor the protect register.
- R8: A write to one port leaves the latches of the other five ports unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register select: 0-5 ports, 6 protect register, 7 unused |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at `addr` |
| padIn | input | 48 | Sensed line levels, port k in bits 8k+7:8k |
| padPullLow | output | 48 | Driver enables, 1 pulls the line low |

## Verification
A wrong latch bit shows up on `padPullLow` on the edge after the write that set it, and two edges later as a wrong bit in the port read, so the bench compares both outputs against a behavioural model in every cycle. A protect register that is off by a bit lets a write through, or drops one, and `padPullLow` diverges on the very next edge; the register is also read back directly. A synchronizer of the wrong depth moves a changing external level one cycle early or late in the port read, which the per-cycle comparison catches as soon as an external pattern changes.

// File: rtl/odport_pkg.sv
package odport_pkg;
  localparam int NP = 6;
  localparam int PW = 8;
  localparam int AW = $clog2(NP + 1);
  localparam logic [AW-1:0] MASK_ADDR = AW'(NP);

  typedef struct packed {
    logic [NP-1:0] portWr;
    logic          maskWr;
    logic          rdIsPort;
    logic          rdIsMask;
    logic [AW-1:0] rdPort;
  } ctrlStrobe_t;
endpackage

// File: rtl/odport_ctrl.sv
module odport_ctrl
  import odport_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] wrData,
  output ctrlStrobe_t   strobe,
  output logic [NP-1:0] maskQ
);
  always_comb begin
    strobe = '0;
    if (addr < MASK_ADDR) begin
      strobe.rdIsPort = 1'b1;
      strobe.rdPort   = addr;
      if (wrEn && !maskQ[addr]) strobe.portWr[addr] = 1'b1;
    end else if (addr == MASK_ADDR) begin
      strobe.rdIsMask = 1'b1;
      strobe.maskWr   = wrEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wrData[NP-1:0];
  end

  // R8: at most one port latch is loaded per cycle
  a_r8_single_port_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.portWr));
endmodule

// File: rtl/odport_dpath.sv
module odport_dpath
  import odport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PW-1:0]    wrData,
  input  logic [NP-1:0]    maskQ,
  input  logic [NP*PW-1:0] padIn,
  output logic [NP*PW-1:0] padPullLow,
  output logic [PW-1:0]    rdData
);
  logic [NP-1:0][PW-1:0]             latchQ;
  logic [SYNC_STAGES-1:0][NP*PW-1:0] syncQ;
  logic [NP-1:0][PW-1:0]             pinView;

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                latchQ[p] <= '0;
      else if (strobe.portWr[p]) latchQ[p] <= wrData;
    end

    // R2: an accepted write appears on the drivers after the edge
    a_r2_latch_loads: assert property (@(posedge clk) disable iff (!rstN)
      strobe.portWr[p] |=> padPullLow[p*PW +: PW] == $past(wrData));
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '1;
      else if (s == 0) syncQ[s] <= padIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign padPullLow = latchQ;
  assign pinView    = syncQ[SYNC_STAGES-1];

  always_comb begin
    if (strobe.rdIsPort)      rdData = pinView[strobe.rdPort];
    else if (strobe.rdIsMask) rdData = PW'(maskQ);
    else                      rdData = '0;
  end
endmodule

// File: rtl/odport_bank.sv
module odport_bank
  import odport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    addr,
  input  logic [PW-1:0]    wrData,
  output logic [PW-1:0]    rdData,
  input  logic [NP*PW-1:0] padIn,
  output logic [NP*PW-1:0] padPullLow
);
  ctrlStrobe_t   strobe;
  logic [NP-1:0] maskQ;

  odport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .maskQ(maskQ)
  );

  odport_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .maskQ(maskQ),
    .padIn(padIn), .padPullLow(padPullLow), .rdData(rdData)
  );

  // R3: a protected port ignores the write
  a_r3_protected_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr < MASK_ADDR && maskQ[addr]) |=> $stable(padPullLow));

  // R4: protect register always accepts writes
  a_r4_mask_loads: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == MASK_ADDR) |=> maskQ == $past(wrData[NP-1:0]));

  // R7: the unused address touches no state
  a_r7_unused_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr > MASK_ADDR) |=> ($stable(padPullLow) && $stable(maskQ)));
endmodule

// File: tb/odport_bank_bench.sv
module odport_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] padIn;
  logic [47:0] padPullLow;
  logic [47:0] extLow = '0;

  int    vectors = 0;
  int    misses = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // model state
  logic [47:0] mLatch = '0;
  logic [5:0]  mMask = '0;
  logic [47:0] mS1 = '1;
  logic [47:0] mS2 = '1;

  always #10 clk = ~clk;

  assign padIn = ~(padPullLow | extLow);

  odport_bank u_odport_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padPullLow(padPullLow)
  );

  always @(posedge clk) begin
    logic [47:0] pins;
    if (!rstN) begin
      mLatch = '0; mMask = '0; mS1 = '1; mS2 = '1;
    end else begin
      pins = ~(mLatch | extLow);
      mS2 = mS1;
      mS1 = pins;
      if (wrEn) begin
        if (addr < 3'd6) begin
          if (!mMask[addr]) mLatch[addr*8 +: 8] = wrData;
        end else if (addr == 3'd6) begin
          mMask = wrData[5:0];
        end
      end
    end
  end

  function automatic logic [7:0] expRead();
    if (addr < 3'd6)  return mS2[addr*8 +: 8];
    if (addr == 3'd6) return {2'b00, mMask};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (padPullLow !== mLatch) begin
        misses++;
        $display("FAIL %s padPullLow actual=%h expected=%h", curReq, padPullLow, mLatch);
      end
      vectors++;
      if (rdData !== expRead()) begin
        misses++;
        $display("FAIL %s rdData addr=%0d actual=%h expected=%h", curReq, addr, rdData, expRead());
      end
    end
  end

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    #1;
    wrEn = we; addr = a; wrData = d;
  endtask

  task automatic readAll();
    for (int k = 0; k < 8; k++) step(1'b0, 3'(k), 8'h00);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    for (int k = 0; k < 4; k++) step(1'b0, 3'(k), 8'h00);
    @(negedge clk); #1 rstN = 1'b1;
    readAll();

    // R2 / R8: load each port with its own pattern, others untouched
    curReq = "R2";
    for (int k = 0; k < 6; k++) step(1'b1, 3'(k), 8'hA5 ^ 8'(k * 37));
    step(1'b0, 3'd0, 8'h00);
    curReq = "R8";
    step(1'b1, 3'd3, 8'h0F);
    step(1'b0, 3'd3, 8'h00);

    // R6: readback shows own drive as 0
    curReq = "R6";
    step(1'b0, 3'd0, 8'h00);
    readAll();
    extLow = 48'h00F0_0F00_FF00;
    readAll();

    // R5: release all, external levels seen with two-edge latency
    curReq = "R5";
    for (int k = 0; k < 6; k++) step(1'b1, 3'(k), 8'h00);
    for (int k = 0; k < 6; k++) begin
      extLow = 48'h1 << (k * 9);
      step(1'b0, 3'(k), 8'h00);
      step(1'b0, 3'(k), 8'h00);
      step(1'b0, 3'(k), 8'h00);
    end
    extLow = 48'hFFFF_0000_FFFF;
    step(1'b0, 3'd2, 8'h00);
    extLow = '0;
    step(1'b0, 3'd2, 8'h00);
    step(1'b0, 3'd2, 8'h00);

    // R4: protect register write and readback
    curReq = "R4";
    step(1'b1, 3'd6, 8'hEA);
    step(1'b0, 3'd6, 8'h00);
    step(1'b1, 3'd6, 8'h15);
    step(1'b0, 3'd6, 8'h00);

    // R3: writes to protected ports (0, 2, 4) are dropped
    curReq = "R3";
    for (int k = 0; k < 6; k++) step(1'b1, 3'(k), 8'h3C);
    step(1'b0, 3'd0, 8'h00);
    readAll();

    // R7: unused address
    curReq = "R7";
    step(1'b1, 3'd7, 8'hFF);
    step(1'b0, 3'd7, 8'h00);
    step(1'b0, 3'd6, 8'h00);

    // R4: clear protection, ports writable again
    curReq = "R4";
    step(1'b1, 3'd6, 8'h00);
    for (int k = 0; k < 6; k++) step(1'b1, 3'(k), 8'hFF);
    readAll();
    step(1'b0, 3'd0, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule